// File: doc/BRIEF.md
# Coalescing Store Buffer

The block sits between a write-through cache and the next memory level. It absorbs processor stores so the pipeline does not wait on memory. Each slot covers one aligned block of `WORDS` words of `DATA_W` bits, and a per-word valid mask records which words have been written. A store to a block that is already waiting in a slot is folded into that slot. A store to any other block takes a free slot. When no slot is free and folding is not possible, the store is held off with a ready signal.

Slots are written to memory one at a time, oldest first, over a valid/ready port. The port carries the block address, the whole data line and a word-enable mask. A separate lookup port serves the cache's miss path. The cache presents the missed address there, and the block flags whether any waiting slot holds that block. With no flag, the read may go to memory ahead of the buffered stores. With the flag raised, the cache holds the read until the flag drops, which happens once the slot has been written out.

Addresses are word addresses. The low `log2(WORDS)` bits select the word inside a block, and the remaining upper bits form the block address.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `mem_valid_o` is 0, `st_ready_o` is 1 and `rd_conflict_o` is 0.
- R2: An accepted store to a block held by no slot fills a new slot at the tail. That slot's mask has only bit `st_addr_i[OFF_W-1:0]` set, and the word at that index holds `st_data_i`.
- R3: An accepted store to a block already held by a slot writes its word into that slot. An earlier value of the same word is overwritten, the mask bit is ORed in, and no slot is added.
- R4: `st_ready_o` is 0 exactly when the store cannot be folded into a slot and all `N_ENT` slots are occupied.
- R5: `mem_valid_o` is 1 whenever a slot is occupied. `mem_blk_o` shows the block address of the oldest slot. That slot is removed on the cycle `mem_valid_o` and `mem_ready_i` are both 1, so slots leave in the order they were filled.
- R6: `mem_wmask_o` bit w is 1 exactly for the words written into the presented slot. Word w of `mem_data_o` sits at bits [w*DATA_W +: DATA_W] and holds the last value stored to it.
- R7: `rd_conflict_o` is 1 exactly when `rd_valid_i` is 1 and some occupied slot holds the block of `rd_addr_i`.
- R8: A store to the oldest slot's block in the cycle that slot is accepted by memory is not folded. It takes a new slot, and stalls if none is free.
- R9: A store presented while `st_ready_o` is 0 is dropped and leaves no trace in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request |
| st_addr_i | input | ADDR_W | Store word address |
| st_data_i | input | DATA_W | Store data |
| st_ready_o | output | 1 | Store accepted this cycle when high |
| rd_valid_i | input | 1 | Read-miss lookup request |
| rd_addr_i | input | ADDR_W | Missed word address |
| rd_conflict_o | output | 1 | A waiting slot holds the missed block |
| mem_valid_o | output | 1 | Oldest slot presented to memory |
| mem_ready_i | input | 1 | Memory accepts the presented slot |
| mem_blk_o | output | ADDR_W-OFF_W | Block address of the presented slot |
| mem_data_o | output | WORDS*DATA_W | Data line of the presented slot |
| mem_wmask_o | output | WORDS | Word enables of the presented slot |

## Verification
The embedded properties make two assumptions about the environment. They assume that memory never withdraws a presented slot on its own. They also assume that the cache can present a store and a lookup in the same cycle without any ordering between them. The stimulus drives every input only between clock edges. It draws store and lookup addresses from a small pool of blocks, so folding, head-drain collisions and lookup hits all occur often. It holds `mem_ready_i` low for long stretches to reach the full and stalled states. A behavioural queue model predicts every output on every cycle.

// File: rtl/merge_wbuf_pkg.sv
package merge_wbuf_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wbuf_cam.sv
module wbuf_cam #(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned BLK_W = 14
) (
  input  logic [N_ENT-1:0]            occ_i,
  input  logic [N_ENT-1:0][BLK_W-1:0] blk_i,
  input  logic [BLK_W-1:0]            key_i,
  output logic [N_ENT-1:0]            hit_o
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit_o[g] = occ_i[g] && (blk_i[g] == key_i);
  end
endmodule

// File: rtl/wbuf_ring.sv
module wbuf_ring #(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned IDX_W = 2,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(N_ENT - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= nxt(tail_q);
      if (pop_i)  head_q <= nxt(head_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign full_o  = (cnt_q == CNT_W'(N_ENT));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
  import merge_wbuf_pkg::*;
#(
  parameter int unsigned N_ENT  = 4,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned OFF_W = idx_w(WORDS),
  localparam int unsigned BLK_W = ADDR_W - OFF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    st_valid_i,
  input  logic [ADDR_W-1:0]       st_addr_i,
  input  logic [DATA_W-1:0]       st_data_i,
  output logic                    st_ready_o,
  input  logic                    rd_valid_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic                    rd_conflict_o,
  output logic                    mem_valid_o,
  input  logic                    mem_ready_i,
  output logic [BLK_W-1:0]        mem_blk_o,
  output logic [WORDS*DATA_W-1:0] mem_data_o,
  output logic [WORDS-1:0]        mem_wmask_o
);
  localparam int unsigned IDX_W = idx_w(N_ENT);
  localparam int unsigned CNT_W = $clog2(N_ENT + 1);

  logic [N_ENT-1:0]                        occ_q;
  logic [N_ENT-1:0][BLK_W-1:0]             blk_q;
  logic [N_ENT-1:0][WORDS-1:0]             msk_q;
  logic [N_ENT-1:0][WORDS-1:0][DATA_W-1:0] dat_q;

  logic [IDX_W-1:0] head, tail;
  logic             full, empty;
  logic [N_ENT-1:0] st_hit, rd_hit, head_oh, mrg_vec;
  logic             drain, merge, accept, push;
  logic [BLK_W-1:0] st_blk, rd_blk;
  logic [OFF_W-1:0] st_word;

  assign st_blk  = st_addr_i[ADDR_W-1:OFF_W];
  assign st_word = st_addr_i[OFF_W-1:0];
  assign rd_blk  = rd_addr_i[ADDR_W-1:OFF_W];

  wbuf_cam #(.N_ENT(N_ENT), .BLK_W(BLK_W)) u_st_cam (
    .occ_i(occ_q), .blk_i(blk_q), .key_i(st_blk), .hit_o(st_hit)
  );
  wbuf_cam #(.N_ENT(N_ENT), .BLK_W(BLK_W)) u_rd_cam (
    .occ_i(occ_q), .blk_i(blk_q), .key_i(rd_blk), .hit_o(rd_hit)
  );

  assign mem_valid_o = !empty;
  assign drain       = mem_valid_o && mem_ready_i;
  assign head_oh     = N_ENT'(1) << head;
  // slot leaving this cycle cannot absorb the store
  assign mrg_vec     = st_hit & ~(drain ? head_oh : '0);
  assign merge       = |mrg_vec;
  assign st_ready_o  = merge || !full;
  assign accept      = st_valid_i && st_ready_o;
  assign push        = accept && !merge;
  assign rd_conflict_o = rd_valid_i && (|rd_hit);

  wbuf_ring #(.N_ENT(N_ENT), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ring (
    .clk_i, .rst_ni, .push_i(push), .pop_i(drain),
    .head_o(head), .tail_o(tail), .full_o(full), .empty_o(empty)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic alloc, fold;
    assign alloc = push && (tail == IDX_W'(g));
    assign fold  = accept && mrg_vec[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        occ_q[g] <= 1'b0;
        msk_q[g] <= '0;
      end else begin
        if (drain && head_oh[g]) occ_q[g] <= 1'b0;
        if (alloc) begin
          occ_q[g] <= 1'b1;
          msk_q[g] <= WORDS'(1) << st_word;
        end else if (fold) begin
          msk_q[g] <= msk_q[g] | (WORDS'(1) << st_word);
        end
      end
    end

    always_ff @(posedge clk_i) begin
      if (alloc) blk_q[g] <= st_blk;
      if (alloc || fold) dat_q[g][st_word] <= st_data_i;
    end
  end

  assign mem_blk_o   = blk_q[head];
  assign mem_wmask_o = msk_q[head];
  assign mem_data_o  = dat_q[head];

  // R3
  one_block_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(st_hit));
  // R4
  stall_only_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_ready_o |-> full);
  // R5
  drain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_blk_o)));
  // R6
  nonempty_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_wmask_o != '0));
  // R7
  conflict_needs_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_conflict_o |-> (rd_valid_i && mem_valid_o));
  // R1
  empty_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == '0) |-> !mem_valid_o);
endmodule

// File: tb/merge_wbuf_tb.sv
`timescale 1ns/1ps
module merge_wbuf_tb;
  localparam int NE = 4, NW = 4, DW = 64, AW = 16, OW = 2, BW = AW - OW;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic st_valid = 0, rd_valid = 0, mem_ready = 0;
  logic [AW-1:0] st_addr = '0, rd_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, rd_conflict, mem_valid;
  logic [BW-1:0] mem_blk;
  logic [NW*DW-1:0] mem_data;
  logic [NW-1:0] mem_wmask;

  merge_wbuf u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data), .st_ready_o(st_ready),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_conflict_o(rd_conflict),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_blk_o(mem_blk),
    .mem_data_o(mem_data), .mem_wmask_o(mem_wmask)
  );

  typedef struct { logic [BW-1:0] blk; logic [NW-1:0] msk; logic [DW-1:0] d [NW]; } ent_t;
  ent_t q[$];
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare, advance model
  task automatic cyc(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                     input bit rv, input logic [AW-1:0] ra, input bit mr);
    int mi;
    bit drn, mrg, erdy, econ;
    logic [BW-1:0] sb;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd;
    rd_valid = rv; rd_addr = ra; mem_ready = mr;
    #1;
    sb = sa[AW-1:OW];
    mi = -1; econ = 0;
    foreach (q[i]) begin
      if (q[i].blk == sb) mi = i;
      if (rv && q[i].blk == ra[AW-1:OW]) econ = 1;
    end
    drn  = (q.size() > 0) && mr;
    mrg  = (mi >= 0) && !(mi == 0 && drn);   // R8 head collision is not folded
    erdy = mrg || (q.size() < NE);
    chk(st_ready == erdy, "R4 st_ready", 64'(st_ready), 64'(erdy));
    chk(mem_valid == (q.size() > 0), "R5 mem_valid", 64'(mem_valid), 64'(q.size() > 0));
    chk(rd_conflict == econ, "R7 rd_conflict", 64'(rd_conflict), 64'(econ));
    if (q.size() > 0) begin
      chk(mem_blk == q[0].blk, "R5 mem_blk order", 64'(mem_blk), 64'(q[0].blk));
      chk(mem_wmask == q[0].msk, "R6 mem_wmask", 64'(mem_wmask), 64'(q[0].msk));
      for (int w = 0; w < NW; w++)
        if (q[0].msk[w])
          chk(mem_data[w*DW +: DW] == q[0].d[w], "R6 mem_data word",
              mem_data[w*DW +: DW], q[0].d[w]);
    end
    if (sv && erdy) begin
      if (mrg) begin
        q[mi].msk[sa[OW-1:0]] = 1'b1;
        q[mi].d[sa[OW-1:0]] = sd;
      end else begin
        ent_t e;
        e.blk = sb; e.msk = '0;
        for (int w = 0; w < NW; w++) e.d[w] = '0;
        e.msk[sa[OW-1:0]] = 1'b1;
        e.d[sa[OW-1:0]] = sd;
        q.push_back(e);
      end
    end
    if (drn) void'(q.pop_front());
  endtask

  function automatic logic [AW-1:0] ad(input int b, input int w);
    return AW'(b * NW + w);
  endfunction

  initial begin
    #100_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1;
    chk(st_ready == 1, "R1 st_ready", 64'(st_ready), 1);
    chk(mem_valid == 0, "R1 mem_valid", 64'(mem_valid), 0);
    chk(rd_conflict == 0, "R1 rd_conflict", 64'(rd_conflict), 0);

    // R2 single store allocates
    cyc(1, ad(3, 2), 64'hA2, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(mem_wmask == 4'b0100, "R2 alloc mask", 64'(mem_wmask), 64'h4);
    // R3 fold and overwrite
    cyc(1, ad(3, 0), 64'hA0, 0, 0, 0);
    cyc(1, ad(3, 2), 64'hB2, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(mem_wmask == 4'b0101 && mem_data[2*DW +: DW] == 64'hB2, "R3 fold",
        64'(mem_wmask), 64'h5);
    // fill, then stall on new block
    cyc(1, ad(5, 1), 64'h51, 0, 0, 0);
    cyc(1, ad(6, 3), 64'h63, 0, 0, 0);
    cyc(1, ad(7, 0), 64'h70, 0, 0, 0);
    cyc(1, ad(9, 0), 64'h90, 1, ad(6, 1), 0);     // R4 stall, R7 conflict
    cyc(1, ad(5, 2), 64'h52, 1, ad(8, 0), 0);     // fold while full, R7 miss
    // R8 store to head while head drains: full, so stall
    cyc(1, ad(3, 1), 64'h31, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0);
    // R8 with room: head is block 5, store to it during drain
    cyc(1, ad(5, 3), 64'h53, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk(mem_blk == BW'(6), "R8 head after drain", 64'(mem_blk), 6);
    // R9: drain everything, the stalled block 9 never appears
    for (int k = 0; k < 8; k++) cyc(0, 0, 0, 0, 0, 1);
    chk(mem_valid == 0, "R9 no dropped store drained", 64'(mem_valid), 0);

    // random traffic
    for (int k = 0; k < 6000; k++) begin
      bit sv, rv, mr;
      sv = ($urandom_range(0, 99) < 70);
      rv = ($urandom_range(0, 99) < 50);
      mr = (k % 400 < 150) ? 1'b0 : ($urandom_range(0, 99) < 40);
      cyc(sv, ad($urandom_range(0, 5), $urandom_range(0, 3)), {$urandom, $urandom},
          rv, ad($urandom_range(0, 7), $urandom_range(0, 3)), mr);
    end
    for (int k = 0; k < 10; k++) cyc(0, 0, 0, 0, 0, 1);
    chk(mem_valid == 0, "R5 drained empty", 64'(mem_valid), 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule